// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block produces the fetch address of a small microcontroller core. A 13-bit program counter is updated once per clock from decoded control strobes. The strobes are: step to the next word, jump, call, three forms of return, and an accepted interrupt. Only the lower 4K words of the 8K-word address space are backed by memory. Every address the counter takes is therefore folded into 0000h–0FFFh by clearing the bits above the implemented range.

Calls and interrupt entries save a return address in a dedicated eight-entry hardware stack. The three return strobes restore it. The stack is a circular buffer. A push into a full stack overwrites the oldest entry and sets a sticky overflow flag. A pop from an empty stack sets a sticky underflow flag. Neither condition ever stalls the counter. Both flags, the depth and the counter are cleared only by reset.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes 0000h, `depth` becomes 0, and `ovf` and `unf` become 0. This holds regardless of any other strobe.
- R2: `step` alone loads `pc` with `pc`+1 on the next edge. From 0FFFh it goes to 0000h.
- R3: `jump` loads `pc` with `tgt` with bit 12 cleared. For example, `tgt`=1234h gives 0234h.
- R4: `call` pushes the folded value `pc`+1, loads the folded `tgt`, and raises `depth` by one while `depth` is below 8.
- R5: Each of `ret`, `reti` and `retl` pops the newest stack entry into `pc` and lowers `depth` by one when `depth` is above 0.
- R6: `irq` pushes the current `pc` (the interrupted address) and loads 0004h.
- R7: A push while `depth` is 8 overwrites the oldest entry. `depth` stays 8 and `ovf` is set and stays set until reset. Later pops return the eight newest entries, newest first.
- R8: A pop while `depth` is 0 keeps `depth` at 0 and sets `unf`, which stays set until reset.
- R9: When several strobes are high, the order of precedence is `rst`, then `irq`, then `call`, then `jump`, then any return strobe, then `step`.
- R10: Bit 12 of `pc` is always 0.
- R11: With no strobe high, `pc` and `depth` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Accepted interrupt: save `pc`, go to 0004h |
| step | input | 1 | Sequential advance |
| jump | input | 1 | Load `tgt` |
| call | input | 1 | Save `pc`+1, load `tgt` |
| ret | input | 1 | Return from subroutine |
| reti | input | 1 | Return from interrupt |
| retl | input | 1 | Return carrying a literal (the literal is handled elsewhere) |
| tgt | input | 13 | Jump or call target |
| pc | output | 13 | Current fetch address |
| depth | output | 4 | Number of valid stack entries, 0 to 8 |
| ovf | output | 1 | Sticky stack overflow |
| unf | output | 1 | Sticky stack underflow |

## Verification
A table walks the counter through several patterns:
- sequential steps;
- jumps into both 2K pages;
- calls whose targets have bit 12 set, which separates folding from plain loading;
- nested call and interrupt frames unwound by the three different return strobes, which shows that every return form pops and that the interrupt saves the current address rather than the next one;
- a call from 0FFFh, whose saved return address must fold to 0000h.

Directed runs then cover the following:
- Nine pushes followed by eight pops tell a true circular overwrite apart from a saturating or discarding stack.
- An empty pop exposes the underflow handling.
- Stacked strobe combinations confirm each step of the precedence order.
- Reset raised together with `irq` confirms that reset has top precedence.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

   localparam int unsigned PC_WIDTH_DEF   = 13;
   localparam int unsigned IMPL_BITS_DEF  = 12;
   localparam int unsigned STACK_DEF      = 8;

   typedef enum logic [2:0] {
      ACT_HOLD,
      ACT_INC,
      ACT_JUMP,
      ACT_CALL,
      ACT_POP,
      ACT_VECTOR
   } pc_act_e;

endpackage

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
   parameter int unsigned W     = 13,
   parameter int unsigned DEPTH = 8
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           push,
   input  logic                           pop,
   input  logic [W-1:0]                   wdata,
   output logic [W-1:0]                   rdata,
   output logic [$clog2(DEPTH+1)-1:0]     depth,
   output logic                           ovf,
   output logic                           unf
);

   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH+1);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [W-1:0]  slot [DEPTH];
   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] ptr_up;
   logic [PW-1:0] ptr_dn;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pc_ret_stack: DEPTH must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign ptr_up = wr_ptr + 1'b1;
         assign ptr_dn = wr_ptr - 1'b1;
      end else begin : g_cmp_wrap
         assign ptr_up = (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
         assign ptr_dn = (wr_ptr == '0) ? PW'(DEPTH-1) : wr_ptr - 1'b1;
      end
   endgenerate

   assign rdata = slot[ptr_dn];

   always_ff @(posedge clk) begin
      if (push) begin
         slot[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         depth  <= '0;
         ovf    <= 1'b0;
         unf    <= 1'b0;
      end else if (push) begin
         wr_ptr <= ptr_up;
         if (depth == FULL) begin
            ovf <= 1'b1;
         end else begin
            depth <= depth + 1'b1;
         end
      end else if (pop) begin
         wr_ptr <= ptr_dn;
         if (depth == '0) begin
            unf <= 1'b1;
         end else begin
            depth <= depth - 1'b1;
         end
      end
   end

   // R7
   depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
      depth <= FULL);

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ovf |=> ovf);

   // R7
   full_push_chk: assert property (@(posedge clk) disable iff (rst)
      (push && depth == FULL) |=> (ovf && depth == FULL));

   // R8
   unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      unf |=> unf);

   // R8
   empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
      (pop && !push && depth == '0) |=> (unf && depth == '0));

   push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(push && pop));

endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
   import pc_seq_pkg::*;
#(
   parameter int unsigned          PC_W    = 13,
   parameter int unsigned          IMPL_W  = 12,
   parameter logic [PC_W-1:0]      INT_VEC = 13'h0004
) (
   input  logic [PC_W-1:0] pc,
   input  logic [PC_W-1:0] tgt,
   input  logic [PC_W-1:0] pop_data,
   input  logic            irq,
   input  logic            step,
   input  logic            jump,
   input  logic            call,
   input  logic            any_ret,
   output logic [PC_W-1:0] nxt,
   output logic            push_en,
   output logic [PC_W-1:0] push_data,
   output logic            pop_en
);

   localparam logic [PC_W-1:0] KEEP = PC_W'((64'd1 << IMPL_W) - 64'd1);

   pc_act_e act;
   logic [PC_W-1:0] inc_pc;

   assign inc_pc = (pc + PC_W'(1)) & KEEP;

   always_comb begin
      if (irq)          act = ACT_VECTOR;
      else if (call)    act = ACT_CALL;
      else if (jump)    act = ACT_JUMP;
      else if (any_ret) act = ACT_POP;
      else if (step)    act = ACT_INC;
      else              act = ACT_HOLD;
   end

   always_comb begin
      nxt       = pc;
      push_en   = 1'b0;
      pop_en    = 1'b0;
      push_data = inc_pc;
      unique case (act)
         ACT_VECTOR: begin
            nxt       = INT_VEC & KEEP;
            push_en   = 1'b1;
            push_data = pc;
         end
         ACT_CALL: begin
            nxt     = tgt & KEEP;
            push_en = 1'b1;
         end
         ACT_JUMP: nxt = tgt & KEEP;
         ACT_POP: begin
            nxt    = pop_data & KEEP;
            pop_en = 1'b1;
         end
         ACT_INC:  nxt = inc_pc;
         default:  nxt = pc;
      endcase
   end

   // R10
   fold_range_chk: assert final ((nxt & ~KEEP) == '0);

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
   import pc_seq_pkg::*;
#(
   parameter int unsigned PC_W      = PC_WIDTH_DEF,
   parameter int unsigned IMPL_W    = IMPL_BITS_DEF,
   parameter int unsigned STK_DEPTH = STACK_DEF,
   parameter logic [PC_W-1:0] RST_VEC = '0,
   parameter logic [PC_W-1:0] INT_VEC = PC_W'(4)
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              irq,
   input  logic                              step,
   input  logic                              jump,
   input  logic                              call,
   input  logic                              ret,
   input  logic                              reti,
   input  logic                              retl,
   input  logic [PC_W-1:0]                   tgt,
   output logic [PC_W-1:0]                   pc,
   output logic [$clog2(STK_DEPTH+1)-1:0]    depth,
   output logic                              ovf,
   output logic                              unf
);

   localparam logic [PC_W-1:0] KEEP = PC_W'((64'd1 << IMPL_W) - 64'd1);
   localparam int unsigned CW = $clog2(STK_DEPTH+1);

   generate
      if (IMPL_W > PC_W || IMPL_W < 3) begin : g_bad_impl
         $error("pc_sequencer: IMPL_W must lie between 3 and PC_W");
      end
   endgenerate

   logic [PC_W-1:0] nxt;
   logic [PC_W-1:0] push_data;
   logic [PC_W-1:0] pop_data;
   logic            push_en;
   logic            pop_en;
   logic            any_ret;

   assign any_ret = ret | reti | retl;

   pc_next_sel #(
      .PC_W    (PC_W),
      .IMPL_W  (IMPL_W),
      .INT_VEC (INT_VEC)
   ) u_sel (
      .pc        (pc),
      .tgt       (tgt),
      .pop_data  (pop_data),
      .irq       (irq),
      .step      (step),
      .jump      (jump),
      .call      (call),
      .any_ret   (any_ret),
      .nxt       (nxt),
      .push_en   (push_en),
      .push_data (push_data),
      .pop_en    (pop_en)
   );

   pc_ret_stack #(
      .W     (PC_W),
      .DEPTH (STK_DEPTH)
   ) u_stk (
      .clk   (clk),
      .rst   (rst),
      .push  (push_en & ~rst),
      .pop   (pop_en & ~rst),
      .wdata (push_data),
      .rdata (pop_data),
      .depth (depth),
      .ovf   (ovf),
      .unf   (unf)
   );

   always_ff @(posedge clk) begin
      if (rst) pc <= RST_VEC & KEEP;
      else     pc <= nxt;
   end

   // R2
   step_inc_chk: assert property (@(posedge clk) disable iff (rst)
      (step && !irq && !call && !jump && !any_ret) |=> pc == (($past(pc) + PC_W'(1)) & KEEP));

   // R6
   irq_vec_chk: assert property (@(posedge clk) disable iff (rst)
      irq |=> pc == (INT_VEC & KEEP));

   // R4
   call_depth_chk: assert property (@(posedge clk) disable iff (rst)
      (call && depth < CW'(STK_DEPTH)) |=> depth == $past(depth) + 1'b1);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(irq || step || jump || call || any_ret) |=> ($stable(pc) && $stable(depth)));

   // R10
   pc_range_chk: assert property (@(posedge clk) disable iff (rst)
      (pc & ~KEEP) == '0);

endmodule

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        irq = 1'b0, step = 1'b0, jump = 1'b0, call = 1'b0;
   logic        ret = 1'b0, reti = 1'b0, retl = 1'b0;
   logic [12:0] tgt = '0;
   logic [12:0] pc;
   logic [3:0]  depth;
   logic        ovf, unf;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pc_sequencer u0 (
      .clk(clk), .rst(rst), .irq(irq), .step(step), .jump(jump), .call(call),
      .ret(ret), .reti(reti), .retl(retl), .tgt(tgt),
      .pc(pc), .depth(depth), .ovf(ovf), .unf(unf)
   );

   // op codes: 0 none, 1 step, 2 jump, 3 call, 4 ret, 5 reti, 6 retl, 7 irq
   // entry: {op[2:0], tgt[12:0], expected pc[12:0], expected depth[3:0]}
   localparam logic [32:0] VEC [15] = '{
      {3'd1, 13'h0000, 13'h0001, 4'd0},   // R2
      {3'd1, 13'h0000, 13'h0002, 4'd0},   // R2
      {3'd2, 13'h0800, 13'h0800, 4'd0},   // R3
      {3'd3, 13'h1100, 13'h0100, 4'd1},   // R4 folded target
      {3'd1, 13'h0000, 13'h0101, 4'd1},   // R2
      {3'd7, 13'h0000, 13'h0004, 4'd2},   // R6
      {3'd5, 13'h0000, 13'h0101, 4'd1},   // R5 reti
      {3'd4, 13'h0000, 13'h0801, 4'd0},   // R5 ret
      {3'd2, 13'h1FFF, 13'h0FFF, 4'd0},   // R3
      {3'd1, 13'h0000, 13'h0000, 4'd0},   // R2 wrap
      {3'd3, 13'h0FFF, 13'h0FFF, 4'd1},   // R4
      {3'd3, 13'h0010, 13'h0010, 4'd2},   // R4 pushes folded 0000
      {3'd6, 13'h0000, 13'h0000, 4'd1},   // R5 retl
      {3'd6, 13'h0000, 13'h0001, 4'd0},   // R5 retl
      {3'd0, 13'h0ABC, 13'h0001, 4'd0}    // R11
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_strobes();
      irq = 0; step = 0; jump = 0; call = 0; ret = 0; reti = 0; retl = 0; rst = 0;
   endtask

   task automatic drive_op(input logic [2:0] op, input logic [12:0] t);
      clear_strobes();
      tgt = t;
      case (op)
         3'd1: step = 1;
         3'd2: jump = 1;
         3'd3: call = 1;
         3'd4: ret  = 1;
         3'd5: reti = 1;
         3'd6: retl = 1;
         3'd7: irq  = 1;
         default: ;
      endcase
      @(posedge clk);
      @(negedge clk);
      clear_strobes();
   endtask

   task automatic do_reset();
      clear_strobes();
      rst = 1;
      @(posedge clk);
      @(negedge clk);
      rst = 0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      check("R1 pc", 32'(pc), 32'h0);
      check("R1 depth", 32'(depth), 32'd0);
      check("R1 flags", {30'd0, ovf, unf}, 32'd0);

      for (int i = 0; i < 15; i++) begin
         drive_op(VEC[i][32:30], VEC[i][29:17]);
         check($sformatf("R2-R6 vec%0d pc", i), 32'(pc), 32'(VEC[i][16:4]));
         check($sformatf("R4 R5 vec%0d depth", i), 32'(depth), 32'(VEC[i][3:0]));
      end

      // R7: nine calls, the first saved address (0001h) is lost
      do_reset();
      for (int k = 1; k <= 9; k++) begin
         drive_op(3'd3, 13'(k * 16));
      end
      check("R7 depth full", 32'(depth), 32'd8);
      check("R7 ovf set", 32'(ovf), 32'd1);
      for (int k = 8; k >= 1; k--) begin
         drive_op(3'd4, 13'h0);
         check("R7 pop order", 32'(pc), 32'(k * 16 + 1));
      end
      check("R7 depth empty", 32'(depth), 32'd0);
      check("R7 ovf sticky", 32'(ovf), 32'd1);
      check("R8 unf clear before", 32'(unf), 32'd0);

      // R8: pop on empty
      drive_op(3'd5, 13'h0);
      check("R8 unf set", 32'(unf), 32'd1);
      check("R8 depth stays 0", 32'(depth), 32'd0);
      drive_op(3'd1, 13'h0);
      check("R8 unf sticky", 32'(unf), 32'd1);

      // R9: precedence
      do_reset();
      drive_op(3'd2, 13'h0200);
      irq = 1; call = 1; jump = 1; step = 1; ret = 1; tgt = 13'h0300;
      @(posedge clk); @(negedge clk); clear_strobes();
      check("R9 irq first pc", 32'(pc), 32'h0004);
      check("R9 irq first depth", 32'(depth), 32'd1);
      call = 1; jump = 1; ret = 1; step = 1; tgt = 13'h0300;
      @(posedge clk); @(negedge clk); clear_strobes();
      check("R9 call over jump", 32'(pc), 32'h0300);
      check("R9 call depth", 32'(depth), 32'd2);
      jump = 1; retl = 1; step = 1; tgt = 13'h0400;
      @(posedge clk); @(negedge clk); clear_strobes();
      check("R9 jump over return", 32'(pc), 32'h0400);
      check("R9 jump depth", 32'(depth), 32'd2);
      reti = 1; step = 1;
      @(posedge clk); @(negedge clk); clear_strobes();
      check("R9 return over step", 32'(pc), 32'h0005);
      check("R9 return depth", 32'(depth), 32'd1);

      // R1: reset wins over irq and clears flags
      drive_op(3'd4, 13'h0);
      drive_op(3'd4, 13'h0);
      check("R8 unf before reset", 32'(unf), 32'd1);
      rst = 1; irq = 1;
      @(posedge clk); @(negedge clk); clear_strobes();
      check("R1 R9 reset pc", 32'(pc), 32'h0);
      check("R1 reset depth", 32'(depth), 32'd0);
      check("R1 reset flags", {30'd0, ovf, unf}, 32'd0);

      // R10 / R3: bit 12 never set
      drive_op(3'd2, 13'h1FFE);
      check("R10 bit12 clear", 32'(pc[12]), 32'd0);
      check("R3 fold", 32'(pc), 32'h0FFE);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule